// File: doc/BRIEF.md
# Serial Receiver with Mute Wakeup

This block is the receive half of an asynchronous serial port. It watches the RX line on a 16x oversampling tick, finds the falling edge of a start bit, resolves every bit by a three-sample majority vote around its centre, and assembles a word of 8 or 9 data bits sent least significant bit first. An optional parity bit follows the word and is checked with even or odd sense. Each accepted word is held in a data register and raises a receive-not-empty flag. A read acknowledge pulse clears that flag.

A mute mode lets a node on a shared line ignore traffic that is not meant for it. While muted, received words raise no flags. The node leaves mute mode in one of two ways, chosen by a configuration bit. In the first, the line stays idle for one whole frame time. In the second, a word arrives with its most significant bit set; that word is an address marker and is delivered normally. Two interlocks guard the mute bit. Idle wakeup only works once the receiver has delivered at least one word. In address-marker mode, software cannot write the mute bit while unread data is pending.

An idle-line flag, a parity-error flag and an interrupt request complete the outputs. The interrupt request is the OR of the three flags, each gated by its own enable.

Top module: `uart_rx_mute`

## Requirements
- R1: A frame starts at the first oversample tick on which the synchronised line is low. If the majority vote at the centre of the start bit reads high, the frame is dropped and the receiver goes back to searching, with no flag raised.
- R2: Data bits are taken least significant bit first. With `cfg_nine_bit` at 0 the word is 8 bits and `rx_data[8]` reads 0; with it at 1 the word is 9 bits. A delivered word appears on `rx_data` and sets `rxne`.
- R3: Each bit resolves to the majority of the samples at ticks OVS/2-1, OVS/2 and OVS/2+1 of its bit time, counted from 0 at the start edge. A single inverted tick at OVS/2 does not change the bit.
- R4: With `cfg_par_en` at 1, one parity bit follows the word. The count of ones over the word and the parity bit must be even when `cfg_par_odd` is 0 and odd when it is 1. On a mismatch `perr_flag` is set together with `rxne`.
- R5: `rxne` and `perr_flag` stay set until a `rd_ack` pulse clears them.
- R6: After a frame, once the line has been high for (word bits + parity bit + 2) x OVS ticks, `idle_flag` is set. It is set at most once per received frame and is cleared by `idle_ack`.
- R7: While `mute` is 1, the receiver sets none of `rxne`, `idle_flag` or `perr_flag`. The one exception is the waking word of R9.
- R8: With `cfg_wake_addr` at 0, a muted receiver clears `mute` at the idle point of R6 and does not set `idle_flag`. This happens only if a word has been delivered since reset; otherwise `mute` stays 1.
- R9: With `cfg_wake_addr` at 1, a muted receiver clears `mute` on a word whose most significant bit (bit 7 for 8-bit words, bit 8 for 9-bit words) is 1, and delivers that word. Words with that bit at 0 are dropped.
- R10: A `mute_wr` pulse loads `mute_wr_val` into `mute`. With `cfg_wake_addr` at 1 and `rxne` set, the write is ignored.
- R11: While `cfg_enable` or `cfg_rx_en` is 0, activity on `rx_i` delivers nothing.
- R12: `irq` is 1 exactly when some flag is set whose enable (`ie_perr`, `ie_rxne`, `ie_idle`) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit by default |
| rx_i | input | 1 | Serial line, idle high |
| cfg_enable | input | 1 | Block enable |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_nine_bit | input | 1 | 1: 9-bit words, 0: 8-bit words |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_wake_addr | input | 1 | 1: wake on marker bit, 0: wake on idle line |
| mute_wr | input | 1 | Write strobe for the mute bit |
| mute_wr_val | input | 1 | Value written to the mute bit |
| rd_ack | input | 1 | Data read; clears rxne and perr_flag |
| idle_ack | input | 1 | Clears idle_flag |
| ie_perr | input | 1 | Parity-error interrupt enable |
| ie_rxne | input | 1 | Receive-not-empty interrupt enable |
| ie_idle | input | 1 | Idle interrupt enable |
| rx_data | output | 9 | Last delivered word |
| rxne | output | 1 | Receive-not-empty flag |
| idle_flag | output | 1 | Idle-line flag |
| perr_flag | output | 1 | Parity error on the last delivered word |
| mute | output | 1 | Receiver is muted |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the receiver with an oversampling ratio of 8 instead of 16. This moves the sample points to ticks 3, 4 and 5 and shortens every bit, so the derived sample points and the frame-time idle limit are checked at a value other than the default. That shorter frame keeps long idle stretches, repeated mute entry and exit in both wakeup modes, and both word lengths with and without parity affordable within one run. A single-tick glitch placed on the centre sample and a start pulse shorter than half a bit probe the vote and false-start paths.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  parameter int unsigned WORD_W = 9;

  typedef enum logic {RX_WAIT, RX_FRAME} rx_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic              par_bad;
  } rx_frame_t;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rx,
  input  logic      active,
  input  logic      nine_bit,
  input  logic      par_en,
  input  logic      par_odd,
  output logic      busy,
  output logic      done,
  output rx_frame_t frame
);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned IW = $clog2(WORD_W + 4);
  localparam logic [CW-1:0] SMP_A   = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] SMP_B   = CW'(OVS / 2);
  localparam logic [CW-1:0] SMP_C   = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(OVS - 1);

  rx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [1:0]        smp_q, smp_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              par_q, par_d;
  logic              done_q, done_d;
  logic [IW-1:0]     nbits, stop_idx;
  logic              vote;

  assign nbits    = nine_bit ? IW'(WORD_W) : IW'(WORD_W - 1);
  assign stop_idx = nbits + IW'(par_en) + IW'(1);
  assign vote     = (smp_q[0] & smp_q[1]) | (smp_q[0] & rx) | (smp_q[1] & rx);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    smp_d   = smp_q;
    word_d  = word_q;
    par_d   = par_q;
    done_d  = 1'b0;
    if (!active) begin
      state_d = RX_WAIT;
    end else if (tick) begin
      case (state_q)
        RX_WAIT: begin
          if (!rx) begin
            state_d = RX_FRAME;
            cnt_d   = CW'(1);
            idx_d   = '0;
            word_d  = '0;
            par_d   = 1'b0;
          end
        end
        default: begin
          if (cnt_q == SMP_A) smp_d[0] = rx;
          if (cnt_q == SMP_B) smp_d[1] = rx;
          if (cnt_q == SMP_C) begin
            if (idx_q == '0) begin
              if (vote) state_d = RX_WAIT;
            end else if (idx_q == stop_idx) begin
              done_d  = 1'b1;
              state_d = RX_WAIT;
            end else if (idx_q <= nbits) begin
              for (int i = 0; i < WORD_W; i++) begin
                if (idx_q == IW'(i + 1)) word_d[i] = vote;
              end
            end else begin
              par_d = vote;
            end
          end
          if (cnt_q == CNT_TOP) begin
            cnt_d = '0;
            idx_d = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_WAIT;
      cnt_q   <= '0;
      idx_q   <= '0;
      smp_q   <= '0;
      word_q  <= '0;
      par_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      smp_q   <= smp_d;
      word_q  <= word_d;
      par_q   <= par_d;
      done_q  <= done_d;
    end
  end

  assign busy          = (state_q == RX_FRAME);
  assign done          = done_q;
  assign frame.word    = word_q;
  assign frame.par_bad = par_en & (^word_q ^ par_q ^ par_odd);
endmodule

// File: rtl/uart_rx_idle_det.sv
module uart_rx_idle_det
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx,
  input  logic active,
  input  logic busy,
  input  logic frame_done,
  input  logic nine_bit,
  input  logic par_en,
  output logic idle_evt
);
  localparam int unsigned FRAME_MAX = (WORD_W + 3) * OVS;
  localparam int unsigned CW        = $clog2(FRAME_MAX + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  logic          evt_q, evt_d;
  logic [CW-1:0] limit;

  assign limit = CW'((32'(nine_bit ? WORD_W : WORD_W - 1) + 32'(par_en) + 32'd2) * OVS);

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    evt_d   = 1'b0;
    if (!active) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (frame_done) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (busy || !rx) begin
      cnt_d = '0;
    end else if (tick && armed_q) begin
      if (cnt_q == limit - 1'b1) begin
        evt_d   = 1'b1;
        armed_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      evt_q   <= evt_d;
    end
  end

  assign idle_evt = evt_q;
endmodule

// File: rtl/uart_rx_mute_ctrl.sv
module uart_rx_mute_ctrl
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  rx_frame_t         frame,
  input  logic              nine_bit,
  input  logic              wake_addr,
  input  logic              idle_evt,
  input  logic              mute_wr,
  input  logic              mute_wr_val,
  input  logic              rd_ack,
  input  logic              idle_ack,
  output logic [WORD_W-1:0] rx_data,
  output logic              rxne,
  output logic              idle_flag,
  output logic              perr_flag,
  output logic              mute
);
  logic [WORD_W-1:0] data_q, data_d;
  logic rxne_q, rxne_d, idle_q, idle_d, perr_q, perr_d;
  logic mute_q, mute_d, seen_q, seen_d;
  logic marked, deliver, hw_wake, wr_ok;

  assign marked  = nine_bit ? frame.word[WORD_W-1] : frame.word[WORD_W-2];
  assign deliver = frame_done && (!mute_q || (wake_addr && marked));
  assign hw_wake = mute_q && ((frame_done && wake_addr && marked) ||
                              (idle_evt && !wake_addr && seen_q));
  assign wr_ok   = mute_wr && !(wake_addr && rxne_q);

  always_comb begin
    data_d = deliver ? frame.word : data_q;
    seen_d = seen_q | deliver;
    if (deliver)     rxne_d = 1'b1;
    else if (rd_ack) rxne_d = 1'b0;
    else             rxne_d = rxne_q;
    if (deliver)     perr_d = frame.par_bad;
    else if (rd_ack) perr_d = 1'b0;
    else             perr_d = perr_q;
    if (idle_evt && !mute_q) idle_d = 1'b1;
    else if (idle_ack)       idle_d = 1'b0;
    else                     idle_d = idle_q;
    if (wr_ok)        mute_d = mute_wr_val;
    else if (hw_wake) mute_d = 1'b0;
    else              mute_d = mute_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rxne_q <= 1'b0;
      idle_q <= 1'b0;
      perr_q <= 1'b0;
      mute_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      data_q <= data_d;
      rxne_q <= rxne_d;
      idle_q <= idle_d;
      perr_q <= perr_d;
      mute_q <= mute_d;
      seen_q <= seen_d;
    end
  end

  assign rx_data   = data_q;
  assign rxne      = rxne_q;
  assign idle_flag = idle_q;
  assign perr_flag = perr_q;
  assign mute      = mute_q;
endmodule

// File: rtl/uart_rx_mute.sv
module uart_rx_mute
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_i,
  input  logic              cfg_enable,
  input  logic              cfg_rx_en,
  input  logic              cfg_nine_bit,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_wake_addr,
  input  logic              mute_wr,
  input  logic              mute_wr_val,
  input  logic              rd_ack,
  input  logic              idle_ack,
  input  logic              ie_perr,
  input  logic              ie_rxne,
  input  logic              ie_idle,
  output logic [WORD_W-1:0] rx_data,
  output logic              rxne,
  output logic              idle_flag,
  output logic              perr_flag,
  output logic              mute,
  output logic              irq
);
  logic [1:0] rst_sync_q;
  logic [1:0] rx_sync_q;
  logic       rst_int, rx_s, active, rx_busy, frame_done, idle_evt;
  rx_frame_t  frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) rx_sync_q <= 2'b11;
    else          rx_sync_q <= {rx_sync_q[0], rx_i};
  end
  assign rx_s   = rx_sync_q[1];
  assign active = cfg_enable & cfg_rx_en;

  uart_rx_sampler #(.OVS(OVS)) sampler_i (
    .clk(clk), .rst_n(rst_int), .tick(os_tick), .rx(rx_s), .active(active),
    .nine_bit(cfg_nine_bit), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .busy(rx_busy), .done(frame_done), .frame(frame)
  );

  uart_rx_idle_det #(.OVS(OVS)) idle_i (
    .clk(clk), .rst_n(rst_int), .tick(os_tick), .rx(rx_s), .active(active),
    .busy(rx_busy), .frame_done(frame_done), .nine_bit(cfg_nine_bit),
    .par_en(cfg_par_en), .idle_evt(idle_evt)
  );

  uart_rx_mute_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_int), .frame_done(frame_done), .frame(frame),
    .nine_bit(cfg_nine_bit), .wake_addr(cfg_wake_addr), .idle_evt(idle_evt),
    .mute_wr(mute_wr), .mute_wr_val(mute_wr_val), .rd_ack(rd_ack),
    .idle_ack(idle_ack), .rx_data(rx_data), .rxne(rxne),
    .idle_flag(idle_flag), .perr_flag(perr_flag), .mute(mute)
  );

  assign irq = (perr_flag & ie_perr) | (rxne & ie_rxne) | (idle_flag & ie_idle);
endmodule

// File: rtl/uart_rx_mute_chk.sv
module uart_rx_mute_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_enable,
  input logic cfg_rx_en,
  input logic cfg_wake_addr,
  input logic mute_wr,
  input logic mute_wr_val,
  input logic rd_ack,
  input logic rxne,
  input logic idle_flag,
  input logic perr_flag,
  input logic mute,
  input logic rx_busy,
  input logic frame_done,
  input logic idle_evt
);
  p_mute_blocks_rxne_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rxne) && $past(mute) && !$past(mute_wr)) |-> (cfg_wake_addr && !mute));

  p_mute_blocks_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_flag) |-> !$past(mute));

  p_mute_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_wr && mute_wr_val && !mute && cfg_wake_addr && rxne) |=> !mute);

  p_rxne_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rxne && !rd_ack) |=> rxne);

  p_perr_with_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    perr_flag |-> rxne);

  p_mute_exit_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute) |-> ($past(mute_wr) || $past(frame_done) || $past(idle_evt)));

  p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable || !cfg_rx_en) |=> !rx_busy);
endmodule

bind uart_rx_mute uart_rx_mute_chk chk_i (
  .clk(clk), .rst_n(rst_int), .cfg_enable(cfg_enable), .cfg_rx_en(cfg_rx_en),
  .cfg_wake_addr(cfg_wake_addr), .mute_wr(mute_wr), .mute_wr_val(mute_wr_val),
  .rd_ack(rd_ack), .rxne(rxne), .idle_flag(idle_flag), .perr_flag(perr_flag),
  .mute(mute), .rx_busy(rx_busy), .frame_done(frame_done), .idle_evt(idle_evt)
);

// File: tb/uart_rx_mute_tb.sv
`timescale 1ns/1ps
module uart_rx_mute_tb_top;
  localparam int OVS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic rx_i = 1'b1;
  logic cfg_enable = 1'b1, cfg_rx_en = 1'b1, cfg_nine_bit = 1'b0;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_wake_addr = 1'b0;
  logic mute_wr = 1'b0, mute_wr_val = 1'b0, rd_ack = 1'b0, idle_ack = 1'b0;
  logic ie_perr = 1'b0, ie_rxne = 1'b0, ie_idle = 1'b0;
  logic [8:0] rx_data;
  logic rxne, idle_flag, perr_flag, mute, irq;

  int errors = 0;
  int checks = 0;
  bit running = 1'b0;
  int div = 0;

  always #2.5 clk = ~clk;

  uart_rx_mute #(.OVS(OVS)) dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_i(rx_i),
    .cfg_enable(cfg_enable), .cfg_rx_en(cfg_rx_en), .cfg_nine_bit(cfg_nine_bit),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_wake_addr(cfg_wake_addr),
    .mute_wr(mute_wr), .mute_wr_val(mute_wr_val), .rd_ack(rd_ack), .idle_ack(idle_ack),
    .ie_perr(ie_perr), .ie_rxne(ie_rxne), .ie_idle(ie_idle),
    .rx_data(rx_data), .rxne(rxne), .idle_flag(idle_flag), .perr_flag(perr_flag),
    .mute(mute), .irq(irq)
  );

  // tick every second clock, driven away from the sampling edge
  always @(negedge clk) begin
    div = (div + 1) % 2;
    os_tick <= (div == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R12 reference: compared on every clock once running
  always @(negedge clk) begin
    if (running) begin
      chk("R12 irq", int'(irq),
          int'((perr_flag & ie_perr) | (rxne & ie_rxne) | (idle_flag & ie_idle)));
    end
  end

  task automatic hold(input logic v, input int n);
    rx_i = v;
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      while (!os_tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  function automatic logic par_bit(input logic [8:0] w, input int nb, input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < nb; i++) p = p ^ w[i];
    return p;
  endfunction

  task automatic send(input logic [8:0] w, input int nb, input logic pe,
                      input logic pb, input int glitch);
    hold(1'b0, OVS);
    for (int i = 0; i < nb; i++) begin
      if (i == glitch) begin
        hold(w[i], OVS / 2);
        hold(~w[i], 1);
        hold(w[i], OVS / 2 - 1);
      end else begin
        hold(w[i], OVS);
      end
    end
    if (pe) hold(pb, OVS);
    hold(1'b1, OVS);
    hold(1'b1, 2);
  endtask

  task automatic pulse_rd();
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_idle();
    idle_ack = 1'b1; @(negedge clk); idle_ack = 1'b0; @(negedge clk);
  endtask

  task automatic write_mute(input logic v);
    mute_wr = 1'b1; mute_wr_val = v; @(negedge clk);
    mute_wr = 1'b0; @(negedge clk);
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    running = 1'b1;
    chk("reset rxne", int'(rxne), 0);
    chk("reset idle", int'(idle_flag), 0);
    chk("reset perr", int'(perr_flag), 0);
    chk("reset mute", int'(mute), 0);
    chk("reset data", int'(rx_data), 0);

    // R8: no word delivered yet, idle wakeup must not release mute
    write_mute(1'b1);
    send(9'h011, 8, 1'b0, 1'b0, -1);
    hold(1'b1, 100);
    chk("R8 no-byte mute kept", int'(mute), 1);
    chk("R7 muted rxne", int'(rxne), 0);
    chk("R7 muted idle", int'(idle_flag), 0);
    write_mute(1'b0);
    chk("R10 write clears mute", int'(mute), 0);

    // R2 8-bit word
    send(9'h0A5, 8, 1'b0, 1'b0, -1);
    chk("R2 rxne", int'(rxne), 1);
    chk("R2 data 8-bit", int'(rx_data), 'h0A5);
    ie_rxne = 1'b1; @(negedge clk);
    chk("R12 irq rxne", int'(irq), 1);
    ie_rxne = 1'b0;
    pulse_rd();
    chk("R5 rxne cleared", int'(rxne), 0);

    // R2 9-bit word
    cfg_nine_bit = 1'b1;
    send(9'h1C3, 9, 1'b0, 1'b0, -1);
    chk("R2 data 9-bit", int'(rx_data), 'h1C3);
    pulse_rd();
    cfg_nine_bit = 1'b0;

    // R3 glitch on centre sample
    send(9'h03C, 8, 1'b0, 1'b0, 2);
    chk("R3 glitch ignored", int'(rx_data), 'h03C);
    send(9'h0C3, 8, 1'b0, 1'b0, 7);
    chk("R3 glitch msb", int'(rx_data), 'h0C3);
    pulse_rd();

    // R1 false start then resync
    hold(1'b0, OVS / 2 - 2);
    hold(1'b1, 40);
    chk("R1 false start", int'(rxne), 0);
    send(9'h055, 8, 1'b0, 1'b0, -1);
    chk("R1 resync", int'(rx_data), 'h055);
    pulse_rd();

    // R4 parity
    cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send(9'h007, 8, 1'b1, par_bit(9'h007, 8, 1'b0), -1);
    chk("R4 even good", int'(perr_flag), 0);
    chk("R4 even data", int'(rx_data), 'h007);
    pulse_rd();
    send(9'h007, 8, 1'b1, ~par_bit(9'h007, 8, 1'b0), -1);
    chk("R4 even bad", int'(perr_flag), 1);
    chk("R4 rxne with perr", int'(rxne), 1);
    ie_perr = 1'b1; @(negedge clk);
    chk("R12 irq perr", int'(irq), 1);
    ie_perr = 1'b0;
    pulse_rd();
    chk("R5 perr cleared", int'(perr_flag), 0);
    cfg_par_odd = 1'b1;
    send(9'h0F0, 8, 1'b1, par_bit(9'h0F0, 8, 1'b1), -1);
    chk("R4 odd good", int'(perr_flag), 0);
    pulse_rd();
    send(9'h0F0, 8, 1'b1, ~par_bit(9'h0F0, 8, 1'b1), -1);
    chk("R4 odd bad", int'(perr_flag), 1);
    pulse_rd();
    cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    hold(1'b1, 120);
    pulse_idle();

    // R6 idle detection: limit is 10 * OVS = 80 ticks here
    send(9'h05A, 8, 1'b0, 1'b0, -1);
    pulse_rd();
    hold(1'b1, 60);
    chk("R6 idle not early", int'(idle_flag), 0);
    hold(1'b1, 30);
    chk("R6 idle set", int'(idle_flag), 1);
    ie_idle = 1'b1; @(negedge clk);
    chk("R12 irq idle", int'(irq), 1);
    ie_idle = 1'b0;
    pulse_idle();
    chk("R6 idle ack", int'(idle_flag), 0);
    hold(1'b1, 100);
    chk("R6 idle once", int'(idle_flag), 0);

    // R8 idle wakeup after a delivered word
    write_mute(1'b1);
    send(9'h033, 8, 1'b0, 1'b0, -1);
    chk("R7 muted no rxne", int'(rxne), 0);
    chk("R8 still muted", int'(mute), 1);
    hold(1'b1, 100);
    chk("R8 idle wake", int'(mute), 0);
    chk("R8 no idle flag", int'(idle_flag), 0);

    // R9 address-marker wakeup
    cfg_wake_addr = 1'b1;
    write_mute(1'b1);
    chk("R10 mute set", int'(mute), 1);
    send(9'h005, 8, 1'b0, 1'b0, -1);
    chk("R9 unmarked dropped", int'(rxne), 0);
    chk("R9 still muted", int'(mute), 1);
    send(9'h085, 8, 1'b0, 1'b0, -1);
    chk("R9 marker wakes", int'(mute), 0);
    chk("R9 marker delivered", int'(rxne), 1);
    chk("R9 marker data", int'(rx_data), 'h085);

    // R10 interlock
    write_mute(1'b1);
    chk("R10 write ignored", int'(mute), 0);
    pulse_rd();
    write_mute(1'b1);
    chk("R10 write accepted", int'(mute), 1);
    cfg_nine_bit = 1'b1;
    send(9'h080, 9, 1'b0, 1'b0, -1);
    chk("R9 9-bit bit7 not marker", int'(mute), 1);
    send(9'h101, 9, 1'b0, 1'b0, -1);
    chk("R9 9-bit marker", int'(mute), 0);
    chk("R9 9-bit data", int'(rx_data), 'h101);
    pulse_rd();
    cfg_nine_bit = 1'b0;
    cfg_wake_addr = 1'b0;

    // R11 receiver disabled
    cfg_rx_en = 1'b0;
    send(9'h044, 8, 1'b0, 1'b0, -1);
    chk("R11 rx off", int'(rxne), 0);
    cfg_rx_en = 1'b1;
    cfg_enable = 1'b0;
    send(9'h046, 8, 1'b0, 1'b0, -1);
    chk("R11 block off", int'(rxne), 0);
    cfg_enable = 1'b1;
    hold(1'b1, 4);
    send(9'h099, 8, 1'b0, 1'b0, -1);
    chk("R11 re-enabled", int'(rx_data), 'h099);

    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule